// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block performs one read or one write on an asynchronous 16-bit bus that has separate upper and lower byte strobes. A client presents a transfer on a simple request port: the byte address, the direction, a byte-or-word flag, a 3-bit function code and the write data. The block accepts the request only while idle. It then runs a fixed series of half-clock states, one state per tick of a clock that runs at twice the bus rate. The states are ST_S0 to ST_S7, plus ST_WAIT for stretching and ST_S8 and ST_S9 for an error tail.

Transitions: ST_IDLE goes to ST_S0 on an accepted request. ST_S0 goes to ST_S1, then ST_S2, then ST_S3, then ST_S4. In ST_S4 the synchronized acknowledge and bus-error inputs are sampled. An acknowledge leads to ST_S5. A bus error without an acknowledge also leads to ST_S5 and marks the transfer as failed. When neither is present, the block goes to ST_WAIT and then back to ST_S4, so each wait costs one whole bus clock. After that the path is ST_S5, ST_S6, ST_S7. From ST_S7 a good transfer returns to ST_IDLE. A failed transfer goes on to ST_S8, then ST_S9, then ST_IDLE.

Read data is captured at the close of ST_S6. A one-tick completion pulse carries an error flag: it comes in ST_S7 for a good transfer and in ST_S9 for a failed one. The acknowledge and bus-error inputs are asynchronous and pass through a two-flop synchronizer before the sequencer sees them.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset and whenever idle, req_ready is 1, bus_rnw is 1, bus_as_n, bus_uds_n and bus_lds_n are 1, and bus_addr_oe, bus_dout_oe and rsp_done are 0.
- R2: From the first tick after acceptance (ST_S0) until the transfer returns to idle, bus_fc equals the request's function code and bus_rnw equals its direction (1 = read, 0 = write).
- R3: bus_addr_oe is 1 from ST_S1 through ST_S6, including waits, and 0 from ST_S7 on. While it is 1, bus_addr equals request address bits [AW-1:1].
- R4: bus_as_n is 0 from ST_S2 through ST_S6, including waits, and 1 at every other time. No data strobe is low while bus_as_n is high.
- R5: While the address strobe is low, a word transfer (req_word = 1) drives both bus_uds_n and bus_lds_n low. A byte transfer drives only bus_uds_n low when address bit 0 is 0, and only bus_lds_n low when it is 1.
- R6: DTACK and BERR are seen through two synchronizer flops. If neither is seen in ST_S4, the block adds one ST_WAIT tick and re-samples in ST_S4. Each wait therefore adds two ticks, and all bus outputs hold during ST_S3, ST_S4, ST_WAIT and ST_S5.
- R7: For a read, rsp_rdata at completion equals bus_din as sampled at the clock edge that ends ST_S6.
- R8: A transfer that sees an acknowledge completes with rsp_done high for exactly one tick, in ST_S7, with rsp_err 0. An acknowledge together with a bus error counts as an acknowledge.
- R9: A bus error without an acknowledge completes two ticks later, in ST_S9, with rsp_done and rsp_err both 1.
- R10: For a write, bus_dout_oe is 1 from ST_S3 through ST_S7 and bus_dout equals the request data. For a read, bus_dout_oe stays 0.
- R11: req_valid is ignored while req_ready is 0. A request offered mid-transfer changes neither the running transfer's bus outputs nor its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-state clock (twice the bus rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request, taken while req_ready is 1 |
| req_ready | output | 1 | High while idle |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | AW | Byte address |
| req_fc | input | 3 | Function code for the transfer |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_err | output | 1 | Bus error flag, valid with rsp_done |
| rsp_rdata | output | DW | Read data captured at the end of ST_S6 |
| bus_fc | output | 3 | Function code outputs |
| bus_rnw | output | 1 | Read/write line |
| bus_addr | output | AW-1 | Word address bits [AW-1:1] |
| bus_addr_oe | output | 1 | Address bus output enable |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper byte strobe, active low |
| bus_lds_n | output | 1 | Lower byte strobe, active low |
| bus_dout | output | DW | Write data toward the bus |
| bus_dout_oe | output | 1 | Data bus output enable |
| bus_din | input | DW | Read data from the bus |
| bus_dtack_n | input | 1 | Slave acknowledge, active low, asynchronous |
| bus_berr_n | input | 1 | Bus error, active low, asynchronous |

## Verification
The assertions assume that the slave changes bus_dtack_n and bus_berr_n only while a transfer is running, and that it releases them after the address strobe rises so that no acknowledge is still pending when the next transfer reaches ST_S4. They also assume that a slave which never answers is outside their scope. The stimulus respects these limits: the modelled slave waits a random 0 to 6 ticks after it sees the strobe fall, answers with acknowledge, bus error or both, and releases its lines on the tick where the strobe is seen high. It also places stale data on bus_din from that point, so a late capture would be noticed. Requests offered during a transfer are held for a single tick and always withdrawn before idle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_S4,
        ST_WAIT,
        ST_S5,
        ST_S6,
        ST_S7,
        ST_S8,
        ST_S9
    } bcs_state_e;
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    for (genvar g = 0; g < STAGES; g++) begin : g_st
        logic [W-1:0] q;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= g_st[g-1].q;
            end
        end
    end

    assign q_out = g_st[STAGES-1].q;
endmodule

// File: rtl/bcs_strobe_dec.sv
module bcs_strobe_dec (
    input  logic word,
    input  logic a0,
    output logic upper_en,
    output logic lower_en
);
    always_comb begin
        upper_en = word | ~a0;
        lower_en = word | a0;
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int AW          = 24,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_rnw,
    input  logic          req_word,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_fc,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic [2:0]    bus_fc,
    output logic          bus_rnw,
    output logic [AW-2:0] bus_addr,
    output logic          bus_addr_oe,
    output logic          bus_as_n,
    output logic          bus_uds_n,
    output logic          bus_lds_n,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_oe,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_dtack_n,
    input  logic          bus_berr_n
);
    localparam int NSYNC = 2;

    bcs_state_e state_q, state_d;

    logic [AW-1:0] cap_addr;
    logic          cap_rnw;
    logic          cap_word;
    logic [2:0]    cap_fc;
    logic [DW-1:0] cap_wdata;
    logic [DW-1:0] rdata_q;
    logic          err_q;
    logic          accept;
    logic [NSYNC-1:0] sync_q;
    logic          ack_seen;
    logic          berr_seen;
    logic          upper_en;
    logic          lower_en;

    bcs_sync #(
        .STAGES (SYNC_STAGES),
        .W      (NSYNC),
        .RST_VAL('1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({bus_berr_n, bus_dtack_n}),
        .q_out (sync_q)
    );

    assign ack_seen  = ~sync_q[0];
    assign berr_seen = ~sync_q[1];

    bcs_strobe_dec u_dec (
        .word     (cap_word),
        .a0       (cap_addr[0]),
        .upper_en (upper_en),
        .lower_en (lower_en)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_S0;
            ST_S0:   state_d = ST_S1;
            ST_S1:   state_d = ST_S2;
            ST_S2:   state_d = ST_S3;
            ST_S3:   state_d = ST_S4;
            ST_S4:   state_d = (ack_seen || berr_seen) ? ST_S5 : ST_WAIT;
            ST_WAIT: state_d = ST_S4;
            ST_S5:   state_d = ST_S6;
            ST_S6:   state_d = ST_S7;
            ST_S7:   state_d = err_q ? ST_S8 : ST_IDLE;
            ST_S8:   state_d = ST_S9;
            ST_S9:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and captured transfer fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cap_addr  <= '0;
            cap_rnw   <= 1'b1;
            cap_word  <= 1'b0;
            cap_fc    <= '0;
            cap_wdata <= '0;
            rdata_q   <= '0;
            err_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cap_addr  <= req_addr;
                cap_rnw   <= req_rnw;
                cap_word  <= req_word;
                cap_fc    <= req_fc;
                cap_wdata <= req_wdata;
                err_q     <= 1'b0;
            end
            if (state_q == ST_S4 && (ack_seen || berr_seen))
                err_q <= berr_seen && !ack_seen;
            if (state_q == ST_S6 && cap_rnw)
                rdata_q <= bus_din;
        end
    end

    // bus and response outputs
    always_comb begin
        req_ready   = 1'b0;
        bus_rnw     = cap_rnw;
        bus_addr_oe = 1'b0;
        bus_as_n    = 1'b1;
        bus_uds_n   = 1'b1;
        bus_lds_n   = 1'b1;
        bus_dout_oe = 1'b0;
        rsp_done    = 1'b0;
        rsp_err     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                bus_rnw   = 1'b1;
            end
            ST_S0: ;
            ST_S1: bus_addr_oe = 1'b1;
            ST_S2: begin
                bus_addr_oe = 1'b1;
                bus_as_n    = 1'b0;
                bus_uds_n   = ~upper_en;
                bus_lds_n   = ~lower_en;
            end
            ST_S3, ST_S4, ST_WAIT, ST_S5, ST_S6: begin
                bus_addr_oe = 1'b1;
                bus_as_n    = 1'b0;
                bus_uds_n   = ~upper_en;
                bus_lds_n   = ~lower_en;
                bus_dout_oe = ~cap_rnw;
            end
            ST_S7: begin
                bus_dout_oe = ~cap_rnw;
                rsp_done    = ~err_q;
            end
            ST_S8: ;
            ST_S9: begin
                rsp_done = 1'b1;
                rsp_err  = 1'b1;
            end
            default: ;
        endcase
    end

    assign bus_fc    = cap_fc;
    assign bus_addr  = cap_addr[AW-1:1];
    assign bus_dout  = cap_wdata;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic bus_rnw,
    input logic bus_addr_oe,
    input logic bus_as_n,
    input logic bus_uds_n,
    input logic bus_lds_n,
    input logic bus_dout_oe,
    input logic rsp_done,
    input logic rsp_err
);
    // R4
    strobe_under_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as_n |-> (bus_uds_n && bus_lds_n));

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as_n |-> !(bus_uds_n && bus_lds_n));

    // R3
    addr_under_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr_oe |-> bus_as_n);

    // R10
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_oe |-> !bus_rnw);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    // R11
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (bus_as_n && !bus_addr_oe && !bus_dout_oe && bus_rnw));
endmodule

bind bus_cycle_seq bcs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .bus_rnw     (bus_rnw),
    .bus_addr_oe (bus_addr_oe),
    .bus_as_n    (bus_as_n),
    .bus_uds_n   (bus_uds_n),
    .bus_lds_n   (bus_lds_n),
    .bus_dout_oe (bus_dout_oe),
    .rsp_done    (rsp_done),
    .rsp_err     (rsp_err)
);

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_rnw = 1'b1;
    logic          req_word = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_fc = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_done, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [2:0]    bus_fc;
    logic          bus_rnw;
    logic [AW-2:0] bus_addr;
    logic          bus_addr_oe, bus_as_n, bus_uds_n, bus_lds_n;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_oe;
    logic [DW-1:0] bus_din = '0;
    logic          bus_dtack_n = 1'b1;
    logic          bus_berr_n = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_cycle_seq #(.AW(AW), .DW(DW)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int wait_count(input int d);
        return (d + 1) / 2;
    endfunction

    function automatic int phase_of(input int t, input int w);
        if (t <= 4) return t;
        if (t <= 4 + 2 * w) return 4;
        return t - 2 * w;
    endfunction

    task automatic chk_idle(input string tag);
        chk(req_ready === 1'b1, "R1", {tag, " ready"}, 32'(req_ready), 1);
        chk(bus_rnw === 1'b1 && bus_as_n === 1'b1 && bus_uds_n === 1'b1 && bus_lds_n === 1'b1,
            "R1", {tag, " rnw/strobes"}, {bus_rnw, bus_as_n, bus_uds_n, bus_lds_n}, 4'hf);
        chk(bus_addr_oe === 1'b0 && bus_dout_oe === 1'b0 && rsp_done === 1'b0,
            "R1", {tag, " enables/done"}, {bus_addr_oe, bus_dout_oe, rsp_done}, 0);
    endtask

    // mode: 0 acknowledge, 1 bus error only, 2 both
    task automatic run_xfer(input bit rnw, input bit word, input logic [AW-1:0] addr,
                            input logic [2:0] fc, input logic [DW-1:0] wd,
                            input int mode, input int d, input bit spurious,
                            input logic [DW-1:0] rd);
        int  w    = wait_count(d);
        bit  err  = (mode == 1);
        int  t    = 0;
        bit  seen = 1'b0;
        int  k;
        bit  strobe, up, lo;
        @(negedge clk);
        req_rnw = rnw; req_word = word; req_addr = addr; req_fc = fc; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_fc = ~fc; req_addr = ~addr; req_rnw = ~rnw; req_wdata = ~wd;
        while (!seen && t < 80) begin
            k = phase_of(t, w);
            strobe = (k >= 2 && k <= 6);
            up = strobe && (word || !addr[0]);
            lo = strobe && (word || addr[0]);
            // R2
            chk(bus_fc === fc && bus_rnw === rnw, "R2", "fc/rnw",
                {bus_fc, bus_rnw}, {fc, rnw});
            // R3
            chk(bus_addr_oe === (k >= 1 && k <= 6), "R3", "addr_oe",
                32'(bus_addr_oe), 32'(k >= 1 && k <= 6));
            if (bus_addr_oe === 1'b1)
                chk(bus_addr === addr[AW-1:1], "R3", "addr", 32'(bus_addr), 32'(addr[AW-1:1]));
            // R4 and R6 (waits keep strobes steady)
            chk(bus_as_n === !strobe, "R4", "as_n", 32'(bus_as_n), 32'(!strobe));
            // R5
            chk(bus_uds_n === !up && bus_lds_n === !lo, "R5", "uds/lds",
                {bus_uds_n, bus_lds_n}, {!up, !lo});
            // R10
            chk(bus_dout_oe === (!rnw && k >= 3 && k <= 7), "R10", "dout_oe",
                32'(bus_dout_oe), 32'(!rnw && k >= 3 && k <= 7));
            if (bus_dout_oe === 1'b1)
                chk(bus_dout === wd, "R10", "dout", 32'(bus_dout), 32'(wd));
            // R11: no acceptance mid transfer
            chk(req_ready === 1'b0, "R11", "ready while busy", 32'(req_ready), 0);
            if (rsp_done === 1'b1) begin
                seen = 1'b1;
                // R6 timing through the synchronizer, R8 / R9 end state
                chk(k == (err ? 9 : 7), err ? "R9" : "R8", "done phase", k, err ? 9 : 7);
                chk(t == (err ? 9 : 7) + 2 * w, "R6", "done tick", t, (err ? 9 : 7) + 2 * w);
                chk(rsp_err === err, err ? "R9" : "R8", "err flag", 32'(rsp_err), 32'(err));
                if (rnw && !err)
                    chk(rsp_rdata === rd, "R7", "rdata", 32'(rsp_rdata), 32'(rd));
            end
            // slave model
            if (t == 2 + d) begin
                bus_dtack_n = (mode == 1);
                bus_berr_n  = (mode == 0);
                bus_din     = rd;
            end
            if (t > 2 && bus_as_n === 1'b1) begin
                bus_dtack_n = 1'b1;
                bus_berr_n  = 1'b1;
                bus_din     = ~rd;
            end
            if (spurious) req_valid = (t == 3);
            @(negedge clk);
            t++;
        end
        req_valid = 1'b0;
        if (!seen) chk(1'b0, "R8", "no completion", 0, 1);
        // R8: the pulse has ended and the block is idle again
        chk(rsp_done === 1'b0, "R8", "done one tick", 32'(rsp_done), 0);
        chk_idle("after transfer");
    endtask

    initial begin
        #(5.0 * 100000);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_0a77));
        #1;
        chk_idle("in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("after reset");

        // directed corner cases
        run_xfer(1'b1, 1'b1, 24'h00_1000, 3'd5, 16'h0000, 0, 0, 1'b0, 16'hbeef); // R7 no wait
        run_xfer(1'b0, 1'b0, 24'h00_2002, 3'd1, 16'h1234, 0, 1, 1'b0, 16'h0);    // R5 upper byte
        run_xfer(1'b0, 1'b0, 24'h00_2003, 3'd2, 16'h5678, 0, 2, 1'b1, 16'h0);    // R5 lower, R11
        run_xfer(1'b1, 1'b1, 24'h12_3456, 3'd6, 16'h0000, 1, 3, 1'b0, 16'h0);    // R9 error
        run_xfer(1'b1, 1'b0, 24'h00_0011, 3'd7, 16'h0000, 2, 1, 1'b0, 16'ha55a); // R8 both
        run_xfer(1'b1, 1'b1, 24'hff_fffe, 3'd0, 16'h0000, 0, 6, 1'b1, 16'h0f0f); // R6 long wait
        run_xfer(1'b0, 1'b1, 24'h00_0100, 3'd1, 16'hcafe, 1, 0, 1'b0, 16'h0);    // R9 on write

        // random mix
        for (int i = 0; i < 40; i++) begin
            run_xfer(1'($urandom), 1'($urandom), 24'($urandom), 3'($urandom),
                     16'($urandom), int'($urandom % 3), int'($urandom % 7),
                     1'($urandom), 16'($urandom));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule